// File: doc/BRIEF.md
# Rate-Limiting Dynamic Prescaler

This block thins a stream of single-cycle event pulses so that the output rate can never exceed a fixed ceiling, while a sparse stream passes through almost untouched. Two gate timers take turns. A holdoff timer runs for a fixed number of cycles, and no input pulse is passed while it runs. When it finishes, an acceptance window opens for a bounded number of cycles. The first input pulse that lands inside the window is forwarded, and the same pulse shuts the window and restarts the holdoff. If the window runs its full length with no pulse, it shuts and the holdoff begins again.

Under a dense input the output pulses are therefore spaced by the holdoff plus one cycle, which caps the rate. Under a sparse input the share of pulses passed approaches the window length divided by the sum of both lengths. Both lengths are parameters counted in clock cycles. The input and output are bare pulses with no data attached, so they have no valid/ready handshake and no back-pressure: an input pulse that meets a closed window is simply dropped. A sticky flag reports any window that let more than one pulse through. It stays set until a clear pulse arrives.

Top module: `rdp_prescaler`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, the block is in holdoff: `hold_active`=1, `win_open`=0, `pass_pulse`=0, `multi_err`=0.
- R2: The holdoff lasts exactly HOLD_CYC cycles. An input pulse during any holdoff cycle produces no output.
- R3: The window opens in the cycle after the last holdoff cycle. It stays open for at most WIN_CYC cycles. With no input pulse it closes after exactly WIN_CYC cycles, and the holdoff restarts.
- R4: An input pulse in the first cycle of a window is accepted.
- R5: An input pulse in an open window drives `pass_pulse` high for exactly one cycle, in the following cycle. In that same following cycle the window is closed and the holdoff has begun.
- R6: An input pulse in the first holdoff cycle after an accepted pulse produces no output. A window therefore yields at most one output.
- R7: Exactly one of `win_open` and `hold_active` is high in every cycle.
- R8: Under a pulse in every cycle, consecutive outputs are exactly HOLD_CYC+1 cycles apart.
- R9: `multi_err` is set when a second output would be passed within one window. It stays set until `err_clear` is pulsed, and it remains 0 on correct operation, including across `err_clear` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 1 | Single-cycle input event |
| err_clear | input | 1 | Clears the sticky multi-pass flag |
| pass_pulse | output | 1 | Single-cycle forwarded event, registered |
| win_open | output | 1 | Acceptance window is open |
| hold_active | output | 1 | Holdoff phase is running |
| multi_err | output | 1 | Sticky flag: more than one output in one window |

## Verification
The bench builds the block with HOLD_CYC=4 and WIN_CYC=6. With these short lengths, dozens of full holdoff/window alternations fit into a few hundred cycles. Window timeouts, acceptance in the first window cycle, rejection in the first holdoff cycle, and the exact HOLD_CYC+1 spacing under a saturating input are all reached many times. A sparse pseudo-random stream covers pulses landing at every offset within both phases.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  typedef enum logic {
    PH_HOLD = 1'b0,
    PH_WIN  = 1'b1
  } rdp_phase_e;
endpackage

// File: rtl/rdp_gate_timer.sv
module rdp_gate_timer #(
  parameter int unsigned LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic abort,
  output logic expired
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  always_comb expired = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || abort || expired) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: the count never runs past the phase length
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R3: an idle timer rests at zero
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0) || run);
endmodule

// File: rtl/rdp_phase_ctrl.sv
module rdp_phase_ctrl
  import rdp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_done,
  input  logic       win_done,
  input  logic       accept,
  output rdp_phase_e phase
);
  rdp_phase_e phase_nxt;

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_HOLD: if (hold_done) phase_nxt = PH_WIN;
      PH_WIN:  if (accept || win_done) phase_nxt = PH_HOLD;
      default: phase_nxt = PH_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_HOLD;
    else        phase <= phase_nxt;
  end

  // R5: an accepted pulse closes the window on the next edge
  a_r5_accept_closes: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> phase == PH_HOLD);
  // R3: a timed-out window returns to holdoff
  a_r3_timeout_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WIN && win_done) |=> phase == PH_HOLD);
  // R2: holdoff only ends when its timer expires
  a_r2_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD && !hold_done) |=> phase == PH_HOLD);
endmodule

// File: rtl/rdp_accept_unit.sv
module rdp_accept_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_pulse,
  input  logic win_open,
  output logic accept,
  output logic pass_pulse
);
  always_comb accept = evt_pulse && win_open;

  always_ff @(posedge clk) begin
    if (!rst_n) pass_pulse <= 1'b0;
    else        pass_pulse <= accept;
  end

  // R2: nothing leaves while the window is shut
  a_r2_no_pass_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> !pass_pulse);
  // R5: the output is one cycle wide per accepted pulse
  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pass_pulse |-> !$past(pass_pulse) || $past(accept, 1));
endmodule

// File: rtl/rdp_multi_guard.sv
module rdp_multi_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic win_open,
  input  logic accept,
  input  logic err_clear,
  output logic multi_err
);
  logic win_d;
  logic seen;
  logic open_rise;
  logic err_set;

  always_comb begin
    open_rise = win_open && !win_d;
    err_set   = accept && seen && !open_rise;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_d     <= 1'b0;
      seen      <= 1'b0;
      multi_err <= 1'b0;
    end else begin
      win_d <= win_open;
      if (accept)         seen <= 1'b1;
      else if (open_rise) seen <= 1'b0;
      if (err_set)        multi_err <= 1'b1;
      else if (err_clear) multi_err <= 1'b0;
    end
  end

  // R9: a window never passes a second pulse
  a_r9_one_per_window: assert property (@(posedge clk) disable iff (!rst_n)
    !multi_err);
  // R9: the flag is sticky without a clear
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (multi_err && !err_clear) |=> multi_err);
endmodule

// File: rtl/rdp_prescaler.sv
module rdp_prescaler
  import rdp_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 1000,
  parameter int unsigned WIN_CYC  = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_pulse,
  input  logic err_clear,
  output logic pass_pulse,
  output logic win_open,
  output logic hold_active,
  output logic multi_err
);
  rdp_phase_e phase;
  logic hold_done;
  logic win_done;
  logic accept;

  always_comb begin
    win_open    = (phase == PH_WIN);
    hold_active = (phase == PH_HOLD);
  end

  rdp_gate_timer #(.LEN(HOLD_CYC)) u_hold_tmr (
    .clk(clk), .rst_n(rst_n), .run(hold_active), .abort(1'b0),
    .expired(hold_done)
  );

  rdp_gate_timer #(.LEN(WIN_CYC)) u_win_tmr (
    .clk(clk), .rst_n(rst_n), .run(win_open), .abort(accept),
    .expired(win_done)
  );

  rdp_phase_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .hold_done(hold_done), .win_done(win_done),
    .accept(accept), .phase(phase)
  );

  rdp_accept_unit u_acc (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .win_open(win_open),
    .accept(accept), .pass_pulse(pass_pulse)
  );

  rdp_multi_guard u_guard (
    .clk(clk), .rst_n(rst_n), .win_open(win_open), .accept(accept),
    .err_clear(err_clear), .multi_err(multi_err)
  );

  // R7: exactly one phase status is active
  a_r7_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({win_open, hold_active}) == 1);
  // R5: an output coincides with holdoff having begun
  a_r5_out_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pass_pulse |-> hold_active);
endmodule

// File: tb/rdp_prescaler_test.sv
module rdp_prescaler_test;
  localparam int H = 4;
  localparam int W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_pulse = 1'b0;
  logic err_clear = 1'b0;
  logic pass_pulse, win_open, hold_active, multi_err;

  always #5 clk = ~clk;

  rdp_prescaler #(.HOLD_CYC(H), .WIN_CYC(W)) uut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .err_clear(err_clear),
    .pass_pulse(pass_pulse), .win_open(win_open), .hold_active(hold_active),
    .multi_err(multi_err)
  );

  typedef struct {
    logic  out;
    logic  win;
    string tag;
  } exp_t;

  exp_t exq[$];
  int n_checks = 0;
  int n_errs = 0;
  bit finished = 0;

  // reference phase model, built from the requirements
  bit m_win = 0;
  int m_cnt = 0;
  bit burst = 0;
  int cyc = 0;
  int last_out = -1;
  exp_t it;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic step(input bit ev, input bit clr);
    exp_t e;
    evt_pulse = ev;
    err_clear = clr;
    e.out = ev && m_win;
    if (ev && !m_win && m_cnt == 0) e.tag = "R6";
    else if (ev && !m_win)          e.tag = "R2";
    else if (ev && m_cnt == 0)      e.tag = "R4";
    else if (ev)                    e.tag = "R5";
    else                            e.tag = "R3";
    if (!m_win) begin
      if (m_cnt == H - 1) begin m_win = 1; m_cnt = 0; end
      else m_cnt++;
    end else begin
      if (ev || m_cnt == W - 1) begin m_win = 0; m_cnt = 0; end
      else m_cnt++;
    end
    e.win = m_win;
    exq.push_back(e);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #2;
    if (rst_n && exq.size() > 0) begin
      cyc++;
      it = exq.pop_front();
      check(pass_pulse == it.out, it.tag, int'(pass_pulse), int'(it.out));
      check(win_open == it.win, "R3 window", int'(win_open), int'(it.win));
      check(hold_active == !it.win, "R7", int'(hold_active), int'(!it.win));
      check(multi_err == 1'b0, "R9", int'(multi_err), 0);
      if (pass_pulse && burst) begin
        if (last_out >= 0) check(cyc - last_out == H + 1, "R8", cyc - last_out, H + 1);
        last_out = cyc;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_checks++;
    n_errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check(hold_active == 1'b1, "R1", int'(hold_active), 1);
    check(win_open == 1'b0, "R1", int'(win_open), 0);
    check(pass_pulse == 1'b0, "R1", int'(pass_pulse), 0);
    check(multi_err == 1'b0, "R1", int'(multi_err), 0);
    rst_n = 1'b1;
    #1;
    // R1: first cycle after reset is holdoff
    check(hold_active == 1'b1 && win_open == 1'b0, "R1", int'(win_open), 0);
    // idle: windows time out repeatedly (R3, R2)
    for (int i = 0; i < 3 * (H + W); i++) step(1'b0, 1'b0);
    // pulse in first window cycle (R4): stall until model says window opens next
    while (!(m_win == 0 && m_cnt == H - 1)) step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    // R6: pulse in first holdoff cycle
    step(1'b1, 1'b0);
    for (int i = 0; i < H + W; i++) step(1'b0, 1'b0);
    // pulse at last window cycle
    while (!(m_win == 1 && m_cnt == W - 1)) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    // saturating input (R8)
    burst = 1;
    for (int i = 0; i < 20 * (H + 1); i++) step(1'b1, 1'b0);
    burst = 0;
    step(1'b0, 1'b0);
    // sparse pseudo-random input with occasional clears (R9)
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] == 4'd0, lfsr[7:4] == 4'd5);
    end
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
    @(negedge clk);
    check(exq.size() == 0, "R5 drain", exq.size(), 0);
    finish_run();
  end
endmodule